// File: doc/BRIEF.md
# Write-Once Cache Line Coherence Controller

This block holds the coherence state of one cache line and moves it through four states: Invalid, Valid, Reserved and Dirty. The policy is write-once. The first processor write to a clean shared line is written through to memory, and that write also invalidates the other cached copies. The line then enters Reserved. Any later write makes the line Dirty without touching the bus.

Each cycle the controller looks at two things: the processor request (read or write) and an operation snooped from the shared bus. A snooped operation can be a read, a read-exclusive or a write-once. The controller drives a bus command request, a flush indication, a processor acknowledge and the next line state. The snooped operation takes effect first. The processor request is then judged against the state the snoop leaves behind. A request that needs the bus waits for a grant before the state changes. Tag matching, the data array and bus arbitration sit outside this block.

Top module: `wo_line_ctrl`

## Requirements
- R1: States are encoded as Invalid=2'b00, Valid=2'b01, Reserved=2'b10 and Dirty=2'b11 on `line_state` and `next_state`. Reset puts the line in Invalid.
- R2: A processor read in Invalid raises `bus_req` with `bus_op`=2'b00 (bus read). When granted, the line becomes Valid.
- R3: A processor write in Invalid raises `bus_req` with `bus_op`=2'b01 (read-exclusive). When granted, the line becomes Dirty.
- R4: A processor write in Valid raises `bus_req` with `bus_op`=2'b10 (write-once). When granted, the line becomes Reserved.
- R5: A processor write in Reserved or Dirty leaves the line in Dirty. A processor read in Valid, Reserved or Dirty keeps the state. None of these raises `bus_req`, and each is acknowledged in the same cycle.
- R6: While a request needing the bus has no `bus_gnt`, `pr_ack` stays low, `bus_req` stays high and the state is unchanged.
- R7: A snooped read (`snp_op`=2'b00) in Dirty asserts `flush` and moves the line to Valid. In Reserved it moves the line to Valid without flush. In Valid or Invalid it changes nothing.
- R8: A snooped read-exclusive (2'b01) or write-once (2'b10) moves Valid or Reserved to Invalid without flush. In Dirty it asserts `flush` and moves the line to Invalid.
- R9: The snoop is applied before a processor request in the same cycle, and the request acts on the post-snoop state. In a flush cycle `bus_op` reads 2'b11 (write-back), `bus_req` and `pr_ack` are low, and the processor request stays pending. When the bus is idle, `bus_op` is 2'b00.
- R10: A snoop carrying the unused code 2'b11 has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pr_req | input | 1 | Processor request valid |
| pr_wr | input | 1 | 1 = write, 0 = read |
| bus_gnt | input | 1 | Bus grant for the processor request |
| snp_valid | input | 1 | Snooped bus operation present |
| snp_op | input | 2 | Snooped op: 00 read, 01 read-exclusive, 10 write-once, 11 unused |
| bus_req | output | 1 | Processor-side bus command requested |
| bus_op | output | 2 | 00 read, 01 read-exclusive, 10 write-once, 11 write-back |
| flush | output | 1 | Line must supply its dirty data |
| pr_ack | output | 1 | Processor request completes this cycle |
| next_state | output | 2 | State after this clock edge |
| line_state | output | 2 | Current state |

## Verification
The assertions check several rules on every cycle. A stalled request never moves the state. A flush only comes from a Dirty line, and it blocks both the processor bus request and the acknowledge. A granted write-once lands in Reserved, and a granted read-exclusive lands in Dirty. Local hits never use the bus. The unused snoop code leaves the state alone. Only the bench's ordered scenarios can show the full state walk. Those scenarios cover the ordering of a snoop against a same-cycle processor request, the write-back code during a flush, and a reset taken from Dirty.

// File: rtl/wo_line_ctrl.sv
module wo_line_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pr_req,
  input  logic       pr_wr,
  input  logic       bus_gnt,
  input  logic       snp_valid,
  input  logic [1:0] snp_op,
  output logic       bus_req,
  output logic [1:0] bus_op,
  output logic       flush,
  output logic       pr_ack,
  output logic [1:0] next_state,
  output logic [1:0] line_state
);
  localparam logic [1:0] ST_INV = 2'b00;
  localparam logic [1:0] ST_VAL = 2'b01;
  localparam logic [1:0] ST_RES = 2'b10;
  localparam logic [1:0] ST_DRT = 2'b11;

  localparam logic [1:0] OP_RD  = 2'b00;
  localparam logic [1:0] OP_RDX = 2'b01;
  localparam logic [1:0] OP_WO  = 2'b10;
  localparam logic [1:0] OP_WB  = 2'b11;

  logic [1:0] st_q, mid;
  logic       wb, need_bus, go;
  logic [1:0] req_op;

  always_comb begin
    mid = st_q;
    wb  = 1'b0;
    if (snp_valid) begin
      case (snp_op)
        OP_RD: begin
          if (st_q == ST_DRT) begin mid = ST_VAL; wb = 1'b1; end
          else if (st_q == ST_RES) mid = ST_VAL;
        end
        OP_RDX, OP_WO: begin
          if (st_q == ST_DRT) begin mid = ST_INV; wb = 1'b1; end
          else mid = ST_INV;
        end
        default: ;
      endcase
    end
  end

  assign need_bus = pr_req && (mid == ST_INV || (mid == ST_VAL && pr_wr));
  assign req_op   = (mid == ST_INV) ? (pr_wr ? OP_RDX : OP_RD) : OP_WO;
  assign bus_req  = need_bus && !wb;
  assign go       = pr_req && !wb && (!need_bus || bus_gnt);

  always_comb begin
    next_state = mid;
    if (go) begin
      case (mid)
        ST_INV:  next_state = pr_wr ? ST_DRT : ST_VAL;
        ST_VAL:  next_state = pr_wr ? ST_RES : ST_VAL;
        ST_RES:  next_state = pr_wr ? ST_DRT : ST_RES;
        default: next_state = ST_DRT;
      endcase
    end
  end

  assign bus_op     = wb ? OP_WB : (bus_req ? req_op : OP_RD);
  assign flush      = wb;
  assign pr_ack     = go;
  assign line_state = st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= ST_INV;
    else        st_q <= next_state;
  end
endmodule

// File: rtl/wo_line_ctrl_chk.sv
module wo_line_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pr_req,
  input logic       pr_wr,
  input logic       bus_gnt,
  input logic       snp_valid,
  input logic [1:0] snp_op,
  input logic       bus_req,
  input logic [1:0] bus_op,
  input logic       flush,
  input logic       pr_ack,
  input logic [1:0] line_state
);
  a_r6_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> (line_state == $past(line_state)));

  a_r6_no_ack_without_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |-> !pr_ack);

  a_r9_flush_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!bus_req && !pr_ack && bus_op == 2'b11));

  a_r7_flush_from_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (line_state == 2'b11));

  a_r4_wo_to_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_ack && bus_req && bus_op == 2'b10) |=> (line_state == 2'b10));

  a_r3_rdx_to_dirty: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_ack && bus_req && bus_op == 2'b01) |=> (line_state == 2'b11));

  a_r5_hit_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (pr_req && !snp_valid && line_state != 2'b00 && !(line_state == 2'b01 && pr_wr))
      |-> (!bus_req && pr_ack));

  a_r10_unused_code: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && snp_op == 2'b11 && !pr_req) |=> (line_state == $past(line_state)));
endmodule

bind wo_line_ctrl wo_line_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pr_req(pr_req), .pr_wr(pr_wr), .bus_gnt(bus_gnt),
  .snp_valid(snp_valid), .snp_op(snp_op), .bus_req(bus_req), .bus_op(bus_op),
  .flush(flush), .pr_ack(pr_ack), .line_state(line_state)
);

// File: tb/wo_line_ctrl_test.sv
module wo_line_ctrl_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pr_req = 1'b0, pr_wr = 1'b0, bus_gnt = 1'b0, snp_valid = 1'b0;
  logic [1:0] snp_op = 2'b00;
  logic bus_req, flush, pr_ack;
  logic [1:0] bus_op, next_state, line_state;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  wo_line_ctrl uut (
    .clk(clk), .rst_n(rst_n), .pr_req(pr_req), .pr_wr(pr_wr), .bus_gnt(bus_gnt),
    .snp_valid(snp_valid), .snp_op(snp_op), .bus_req(bus_req), .bus_op(bus_op),
    .flush(flush), .pr_ack(pr_ack), .next_state(next_state), .line_state(line_state)
  );

  // pr wr gnt sv sop | breq bop flush ack nxt
  localparam int NV = 26;
  localparam logic [12:0] VEC [NV] = '{
    13'b1_0_0_0_00_1_00_0_0_00, // R6 read miss stalled
    13'b1_0_1_0_00_1_00_0_1_01, // R2
    13'b1_0_0_0_00_0_00_0_1_01, // R5 read hit V
    13'b1_1_0_0_00_1_10_0_0_01, // R6 write-once stalled
    13'b1_1_1_0_00_1_10_0_1_10, // R4
    13'b1_1_0_0_00_0_00_0_1_11, // R5 R->D
    13'b1_1_0_0_00_0_00_0_1_11, // R5 D->D
    13'b1_0_0_0_00_0_00_0_1_11, // R5 read hit D
    13'b0_0_0_1_00_0_11_1_0_01, // R7 snoop read D
    13'b0_0_0_1_01_0_00_0_0_00, // R8 rdx on V
    13'b1_1_1_0_00_1_01_0_1_11, // R3
    13'b0_0_0_1_01_0_11_1_0_00, // R8 rdx on D
    13'b1_0_1_0_00_1_00_0_1_01, // R2
    13'b1_1_1_0_00_1_10_0_1_10, // R4
    13'b0_0_0_1_00_0_00_0_0_01, // R7 snoop read R
    13'b1_1_1_0_00_1_10_0_1_10, // R4
    13'b0_0_0_1_10_0_00_0_0_00, // R8 wo on R
    13'b1_0_1_0_00_1_00_0_1_01, // R2
    13'b0_0_0_1_10_0_00_0_0_00, // R8 wo on V
    13'b1_1_1_0_00_1_01_0_1_11, // R3
    13'b0_0_0_1_11_0_00_0_0_11, // R10 unused code
    13'b1_1_1_1_00_0_11_1_0_01, // R9 flush blocks write
    13'b1_0_1_1_01_1_00_0_1_01, // R9 rdx then read miss
    13'b1_1_1_1_00_1_10_0_1_10, // R9 snoop read then write-once
    13'b1_1_0_0_00_0_00_0_1_11, // R5 R->D
    13'b0_0_0_1_10_0_11_1_0_00  // R8 wo on D
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1 chk("R1 reset state", {6'd0, line_state}, 8'h00);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      {pr_req, pr_wr, bus_gnt, snp_valid, snp_op} = VEC[i][12:7];
      #1;
      chk($sformatf("R9 vec%0d outputs", i),
          {1'b0, bus_req, bus_op, flush, pr_ack, next_state}, {1'b0, VEC[i][6:0]});
      @(posedge clk); #1;
      chk($sformatf("R1 vec%0d state", i), {6'd0, line_state}, {6'd0, VEC[i][1:0]});
    end
    @(negedge clk);
    {pr_req, pr_wr, bus_gnt, snp_valid, snp_op} = 6'b111000;
    @(posedge clk); #1;
    chk("R3 reach dirty", {6'd0, line_state}, 8'h03);
    @(negedge clk);
    pr_req = 1'b0; rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 reset from dirty", {6'd0, line_state}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1; pr_req = 1'b1; pr_wr = 1'b0; bus_gnt = 1'b0;
    repeat (3) @(posedge clk);
    #1 chk("R6 long stall", {5'd0, pr_ack, line_state}, 8'h00);
    @(negedge clk); pr_req = 1'b0;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule